// File: doc/BRIEF.md
# Standby Power-Up Sequencer

This block orders the start-up of the standby rails once the 5V standby supply is declared good, and later hands the dual rails over to the main supplies when the system wakes. It watches two digitized power-good flags, one for the standby supply and one for the 12V main supply, and a two-bit requested power state that a separate decoder has already resolved from the sleep pins. All timing is measured in whole soft-start intervals, whose length in clock cycles is a parameter.

After the standby flag is seen high, the block idles for one interval and then starts the 3.3V regulator soft-start together with the controlled gate pull of the standby 5V switch. One interval later the switch gate is driven fully on when the 5V dual rail is wanted. When the run state is requested and the 12V flag has been high for three unbroken intervals, the main-path drive is released, the standby switch is turned off and the regulator is put in standby, all on one clock edge. Dropping the standby flag returns everything to the idle state.

A parameter selects between the variant that shuts the 5V dual rail in deep sleep and the variant that keeps it on in every sleep state.

Top module: `standby_seq`

## Requirements
- R1: While `rst` is high, every output is 0 on the clock edge after it is sampled, whatever the flags and request are.
- R2: `ss_en` rises on the clock edge exactly `SS_CYCLES` edges after the first edge that samples `sb_ok` high from idle; it is 0 before that.
- R3: `gate_pull_en` is 1 for exactly `SS_CYCLES` edges starting on the edge `ss_en` rises, when the 5V dual rail is wanted; in the keep-on variant (`KEEP_5V_DEEP`=1) it is always wanted, in the other variant only when `req_state[0]` is 1.
- R4: On the edge that ends soft-start, `gate_pull_en` drops and `sb_gate_low` is set to whether the 5V dual rail is wanted. Request codes: 2'b11 run, 2'b01 suspend, 2'b00 deep sleep, 2'b10 treated as deep sleep; a change of request while waiting for wake updates `sb_gate_low` one edge later.
- R5: `main_release` stays 0 while `main_ok` is low, even with the run request (2'b11) held indefinitely.
- R6: With soft-start finished and run requested, `main_release` and `ldo_standby` rise and `sb_gate_low` falls on the edge `3*SS_CYCLES` edges after the first edge sampling `main_ok` high.
- R7: If `main_ok` is sampled low during that three-interval wait, the wait starts again from zero at the next edge sampling it high.
- R8: Sampling `sb_ok` low in any state drives every output to 0 on that edge, and a later rise restarts the whole sequence from the first interval.
- R9: When the request leaves the run code while handed over, `main_release` and `ldo_standby` drop and `sb_gate_low` returns to its sleep value on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| sb_ok | input | 1 | Standby 5V supply power-good flag |
| main_ok | input | 1 | 12V main supply power-good flag |
| req_state | input | 2 | Requested power state from the decoder |
| ss_en | output | 1 | 3.3V regulator enable, rises at soft-start |
| gate_pull_en | output | 1 | Controlled gate pull for the standby 5V switch |
| sb_gate_low | output | 1 | Standby 5V switch gate pulled low (switch on) |
| main_release | output | 1 | Main-path switch drive released (high impedance) |
| ldo_standby | output | 1 | Internal 3.3V regulator standby command |

## Verification
Start-up is run into deep sleep on both variants at once, which separates the keep-on variant's gate pull and switch-on from the other variant's idle switch, and a later move to suspend shows the switch following the request. The run request is held with the 12V flag low to show the hand-over cannot start early, then the flag is raised and sampled exactly at the three-interval boundary so an off-by-one edge is caught. A one-cycle dip of the 12V flag partway through the wait tells a restarting count from one that merely pauses, and pulling the standby flag both after hand-over and mid soft-start shows a full return to the first interval.

// File: rtl/sbseq_pkg.sv
package sbseq_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_SOFT  = 3'd2,
    ST_READY = 3'd3,
    ST_HOLD  = 3'd4,
    ST_ON    = 3'd5
  } seq_state_t;

  localparam logic [1:0] REQ_DEEP = 2'b00;
  localparam logic [1:0] REQ_SUSP = 2'b01;
  localparam logic [1:0] REQ_RSVD = 2'b10;
  localparam logic [1:0] REQ_RUN  = 2'b11;

  typedef struct packed {
    logic ss_en;
    logic gate_pull_en;
    logic sb_gate_low;
    logic main_release;
    logic ldo_standby;
  } seq_out_t;

endpackage

// File: rtl/sbseq_interval_timer.sv
module sbseq_interval_timer #(
  parameter int SS_CYCLES = 64,
  parameter int SPAN      = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic one_done,
  output logic span_done
);
  localparam int SPAN_CYC = SS_CYCLES * SPAN;
  localparam int CNT_W    = $clog2(SPAN_CYC);
  localparam logic [CNT_W-1:0] ONE_LAST  = CNT_W'(SS_CYCLES - 1);
  localparam logic [CNT_W-1:0] SPAN_LAST = CNT_W'(SPAN_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  // Counts cycles since the last restart; parks at the longest window.
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (cnt_q != SPAN_LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign one_done  = (cnt_q == ONE_LAST);
  assign span_done = (cnt_q == SPAN_LAST);

endmodule

// File: rtl/sbseq_ctrl.sv
module sbseq_ctrl
  import sbseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sb_ok,
  input  logic       main_ok,
  input  logic [1:0] req_state,
  input  logic       one_done,
  input  logic       span_done,
  output seq_state_t state_nxt,
  output logic       restart
);
  seq_state_t state_q;
  logic       run_req;

  assign run_req = (req_state == REQ_RUN);

  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_OFF:   state_nxt = ST_WAIT;
      ST_WAIT:  if (one_done) state_nxt = ST_SOFT;
      ST_SOFT:  if (one_done) state_nxt = ST_READY;
      ST_READY: if (run_req && main_ok) state_nxt = ST_HOLD;
      ST_HOLD: begin
        if (!run_req || !main_ok) state_nxt = ST_READY;
        else if (span_done)       state_nxt = ST_ON;
      end
      ST_ON:    if (!run_req) state_nxt = ST_READY;
      default:  state_nxt = ST_OFF;
    endcase
    // Standby supply loss overrides every state.
    if (!sb_ok) state_nxt = ST_OFF;
  end

  // Every state change opens a fresh timing window.
  assign restart = (state_nxt != state_q);

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_OFF;
    else     state_q <= state_nxt;
  end

endmodule

// File: rtl/sbseq_outputs.sv
module sbseq_outputs
  import sbseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t state_nxt,
  input  logic       rail5_wanted,
  output seq_out_t   outs
);
  seq_out_t outs_d;

  always_comb begin
    outs_d = '0;
    unique case (state_nxt)
      ST_SOFT: begin
        outs_d.ss_en        = 1'b1;
        outs_d.gate_pull_en = rail5_wanted;
      end
      ST_READY, ST_HOLD: begin
        outs_d.ss_en       = 1'b1;
        outs_d.sb_gate_low = rail5_wanted;
      end
      ST_ON: begin
        outs_d.ss_en        = 1'b1;
        outs_d.main_release = 1'b1;
        outs_d.ldo_standby  = 1'b1;
      end
      default: outs_d = '0;
    endcase
  end

  // Registered so every pin moves on the same edge as the state.
  always_ff @(posedge clk) begin
    if (rst) outs <= '0;
    else     outs <= outs_d;
  end

endmodule

// File: rtl/standby_seq.sv
module standby_seq
  import sbseq_pkg::*;
#(
  parameter int SS_CYCLES          = 64,
  parameter int HANDOVER_INTERVALS = 3,
  parameter bit KEEP_5V_DEEP       = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sb_ok,
  input  logic       main_ok,
  input  logic [1:0] req_state,
  output logic       ss_en,
  output logic       gate_pull_en,
  output logic       sb_gate_low,
  output logic       main_release,
  output logic       ldo_standby
);
  seq_state_t state_nxt;
  logic       restart;
  logic       one_done;
  logic       span_done;
  logic       rail5_wanted;
  seq_out_t   outs;

  generate
    if (KEEP_5V_DEEP) begin : g_keep
      assign rail5_wanted = 1'b1;
    end else begin : g_shed
      // Suspend and run codes both have bit 0 set.
      assign rail5_wanted = req_state[0];
    end
  endgenerate

  sbseq_interval_timer #(
    .SS_CYCLES (SS_CYCLES),
    .SPAN      (HANDOVER_INTERVALS)
  ) timer_i (
    .clk       (clk),
    .rst       (rst),
    .restart   (restart),
    .one_done  (one_done),
    .span_done (span_done)
  );

  sbseq_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .sb_ok     (sb_ok),
    .main_ok   (main_ok),
    .req_state (req_state),
    .one_done  (one_done),
    .span_done (span_done),
    .state_nxt (state_nxt),
    .restart   (restart)
  );

  sbseq_outputs outs_i (
    .clk          (clk),
    .rst          (rst),
    .state_nxt    (state_nxt),
    .rail5_wanted (rail5_wanted),
    .outs         (outs)
  );

  assign ss_en        = outs.ss_en;
  assign gate_pull_en = outs.gate_pull_en;
  assign sb_gate_low  = outs.sb_gate_low;
  assign main_release = outs.main_release;
  assign ldo_standby  = outs.ldo_standby;

endmodule

// File: rtl/sbseq_checker.sv
module sbseq_checker (
  input logic clk,
  input logic rst,
  input logic sb_ok,
  input logic main_ok,
  input logic ss_en,
  input logic gate_pull_en,
  input logic sb_gate_low,
  input logic main_release,
  input logic ldo_standby
);

  // R8: standby loss clears every output on the following edge
  a_r8_sb_loss_quiet: assert property (@(posedge clk) disable iff (rst)
    !sb_ok |=> (!ss_en && !gate_pull_en && !sb_gate_low && !main_release && !ldo_standby));

  // R5: hand-over only begins with the main flag seen high
  a_r5_release_needs_main: assert property (@(posedge clk) disable iff (rst)
    $rose(main_release) |-> $past(main_ok));

  // R6: the three hand-over actions land on one edge
  a_r6_handover_together: assert property (@(posedge clk) disable iff (rst)
    $rose(main_release) |-> ($rose(ldo_standby) && $fell(sb_gate_low)));

  // R3: gate pull only while the regulator is enabled
  a_r3_pull_in_soft: assert property (@(posedge clk) disable iff (rst)
    gate_pull_en |-> ss_en);

  // R4: controlled pull and full-on gate never overlap
  a_r4_gate_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(gate_pull_en && sb_gate_low));

  // R9: while handed over, standby switch is off and regulator parked
  a_r9_on_config: assert property (@(posedge clk) disable iff (rst)
    main_release |-> (ldo_standby && !sb_gate_low && ss_en));

  // R2: soft-start begins only from a good standby flag
  a_r2_ss_needs_sb: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_en) |-> $past(sb_ok));

endmodule

bind standby_seq sbseq_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .sb_ok        (sb_ok),
  .main_ok      (main_ok),
  .ss_en        (ss_en),
  .gate_pull_en (gate_pull_en),
  .sb_gate_low  (sb_gate_low),
  .main_release (main_release),
  .ldo_standby  (ldo_standby)
);

// File: tb/standby_seq_tb_top.sv
module standby_seq_tb_top;
  localparam int SS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sb_ok = 1'b0;
  logic main_ok = 1'b0;
  logic [1:0] req_state = 2'b00;

  logic b_ss, b_pull, b_gate, b_rel, b_stby;
  logic k_ss, k_pull, k_gate, k_rel, k_stby;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  standby_seq #(.SS_CYCLES(SS), .HANDOVER_INTERVALS(3), .KEEP_5V_DEEP(1'b0)) dut_i (
    .clk(clk), .rst(rst), .sb_ok(sb_ok), .main_ok(main_ok), .req_state(req_state),
    .ss_en(b_ss), .gate_pull_en(b_pull), .sb_gate_low(b_gate),
    .main_release(b_rel), .ldo_standby(b_stby)
  );

  standby_seq #(.SS_CYCLES(SS), .HANDOVER_INTERVALS(3), .KEEP_5V_DEEP(1'b1)) dut_keep_i (
    .clk(clk), .rst(rst), .sb_ok(sb_ok), .main_ok(main_ok), .req_state(req_state),
    .ss_en(k_ss), .gate_pull_en(k_pull), .sb_gate_low(k_gate),
    .main_release(k_rel), .ldo_standby(k_stby)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_quiet(input string tag);
    chk({tag, " base ss_en"}, b_ss, 1'b0);
    chk({tag, " base gate_pull_en"}, b_pull, 1'b0);
    chk({tag, " base sb_gate_low"}, b_gate, 1'b0);
    chk({tag, " base main_release"}, b_rel, 1'b0);
    chk({tag, " base ldo_standby"}, b_stby, 1'b0);
    chk({tag, " keep ss_en"}, k_ss, 1'b0);
    chk({tag, " keep gate_pull_en"}, k_pull, 1'b0);
    chk({tag, " keep sb_gate_low"}, k_gate, 1'b0);
    chk({tag, " keep main_release"}, k_rel, 1'b0);
    chk({tag, " keep ldo_standby"}, k_stby, 1'b0);
  endtask

  // R1: reset dominates good flags and a run request
  task automatic t_reset();
    rst = 1'b1; sb_ok = 1'b1; main_ok = 1'b1; req_state = 2'b11;
    step(4);
    chk_quiet("R1 reset");
    sb_ok = 1'b0; main_ok = 1'b0; req_state = 2'b00;
    step(1);
    rst = 1'b0;
    step(2);
    chk_quiet("R1 after reset");
  endtask

  // R2 R3 R4: start-up into deep sleep on both variants
  task automatic t_powerup_deep();
    req_state = 2'b00; sb_ok = 1'b1;
    step(SS);
    chk("R2 ss_en before interval", b_ss, 1'b0);
    chk("R2 keep ss_en before interval", k_ss, 1'b0);
    step(1);
    chk("R2 ss_en at interval", b_ss, 1'b1);
    chk("R2 keep ss_en at interval", k_ss, 1'b1);
    chk("R3 keep gate pull starts", k_pull, 1'b1);
    chk("R3 base no gate pull in deep", b_pull, 1'b0);
    step(SS - 1);
    chk("R3 keep gate pull last cycle", k_pull, 1'b1);
    chk("R4 keep gate not yet low", k_gate, 1'b0);
    step(1);
    chk("R3 keep gate pull ends", k_pull, 1'b0);
    chk("R4 keep gate low after soft-start", k_gate, 1'b1);
    chk("R4 base gate stays off in deep", b_gate, 1'b0);
    chk("R2 base ss_en held", b_ss, 1'b1);
  endtask

  // R4: reserved code behaves as deep sleep, suspend turns switch on
  task automatic t_suspend_gate();
    req_state = 2'b10;
    step(2);
    chk("R4 base gate off for code 10", b_gate, 1'b0);
    req_state = 2'b01;
    step(1);
    chk("R4 base gate on for suspend", b_gate, 1'b1);
    chk("R4 keep gate on for suspend", k_gate, 1'b1);
  endtask

  // R5: run request without main flag never hands over
  task automatic t_no_main();
    req_state = 2'b11; main_ok = 1'b0;
    step(5 * SS);
    chk("R5 base no release without main", b_rel, 1'b0);
    chk("R5 keep no release without main", k_rel, 1'b0);
    chk("R5 base regulator not parked", b_stby, 1'b0);
  endtask

  // R6: hand-over exactly three intervals after main flag
  task automatic t_handover();
    main_ok = 1'b1;
    step(3 * SS);
    chk("R6 release not early", b_rel, 1'b0);
    chk("R6 gate still low before", b_gate, 1'b1);
    step(1);
    chk("R6 base release", b_rel, 1'b1);
    chk("R6 base ldo standby", b_stby, 1'b1);
    chk("R6 base gate off", b_gate, 1'b0);
    chk("R6 keep release", k_rel, 1'b1);
    chk("R6 keep ldo standby", k_stby, 1'b1);
    chk("R6 keep gate off", k_gate, 1'b0);
  endtask

  // R9: leaving the run request undoes the hand-over
  task automatic t_sleep_exit();
    req_state = 2'b01;
    step(1);
    chk("R9 release dropped", b_rel, 1'b0);
    chk("R9 ldo standby dropped", b_stby, 1'b0);
    chk("R9 gate back on", b_gate, 1'b1);
    chk("R9 regulator still enabled", b_ss, 1'b1);
  endtask

  // R7: main flag dip restarts the three-interval wait
  task automatic t_main_glitch();
    req_state = 2'b11;
    step(2 * SS);
    main_ok = 1'b0;
    step(1);
    main_ok = 1'b1;
    step(3 * SS);
    chk("R7 no release before restarted wait ends", b_rel, 1'b0);
    chk("R7 keep no release before restarted wait ends", k_rel, 1'b0);
    step(1);
    chk("R7 release after restarted wait", b_rel, 1'b1);
    chk("R7 keep release after restarted wait", k_rel, 1'b1);
  endtask

  // R8: standby loss from hand-over and from mid soft-start
  task automatic t_sb_loss();
    sb_ok = 1'b0;
    step(1);
    chk_quiet("R8 loss after hand-over");
    sb_ok = 1'b1;
    step(SS + 2);
    chk("R8 soft-start running", b_ss, 1'b1);
    sb_ok = 1'b0;
    step(1);
    chk_quiet("R8 loss in soft-start");
    sb_ok = 1'b1;
    step(SS);
    chk("R8 restart waits full interval", b_ss, 1'b0);
    step(1);
    chk("R8 restart ss_en", b_ss, 1'b1);
    chk("R8 restart gate pull run request", b_pull, 1'b1);
  endtask

  initial begin
    step(1);
    t_reset();
    t_powerup_deep();
    t_suspend_gate();
    t_no_main();
    t_handover();
    t_sleep_exit();
    t_main_glitch();
    t_sb_loss();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule